// File: doc/BRIEF.md
# Bus Wait-State Generator with Device Wait Handover

This block drives the CPU's active-low ready line from four decoded, active-low device selects. At the start of each bus cycle it looks up how many wait states the selected device class needs, loads that number into a down-counter, and holds ready low until the counter reaches zero. Two wait states go to the sound device and one to the ROM. The UART, and any cycle with no select asserted, gets no wait state.

A video-chip cycle works differently. The generator inserts one wait state of its own and then passes control of the stall to the video device's active-low wait output. The device can then stretch the bus cycle for as long as it needs. The device wait pin is sampled only on clock edges, and ready comes straight from a flop, so it cannot glitch. The device asserts its wait within a fraction of a clock after the cycle begins. The single generated wait state therefore covers the interval before the device's wait becomes visible.

Address decoding is outside this block. A `cyc_start` strobe marks the first clock of each bus cycle, and the selects are sampled only on that clock edge.

Top module: `wait_handover_gen`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `rdy_n` is 1 and `ws_count` is 0.
- R2: When `cyc_start` is sampled with `snd_sel_n`=0, `ws_count` reads 2 after that edge and `rdy_n` is low for exactly 2 clocks, starting from that edge.
- R3: A cycle that selects only the ROM loads 1 and holds `rdy_n` low for exactly 1 clock.
- R4: A cycle that selects only the UART, or selects nothing, loads 0 and leaves `rdy_n` high.
- R5: When several selects are low at once, the class is chosen in this priority order: sound, then video, then ROM, then UART.
- R6: A video cycle loads 1 into `ws_count`. If `dev_wait_n` is sampled high on the strobe edge, `rdy_n` is low for exactly 1 clock.
- R7: In a video cycle where `dev_wait_n` is low on the strobe edge and on the N-1 edges that follow, and high after that, `rdy_n` is low for exactly 1+N clocks. This is the device wait handover.
- R8: `dev_wait_n` has no effect on sound, ROM, UART or unselected cycles. The stall equals the count loaded for that class.
- R9: Select changes after the strobe edge do not alter the stall of the cycle in progress.
- R10: After a load, `ws_count` falls by one on every clock until it reaches 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock strobe marking the start of a bus cycle |
| rom_sel_n | input | 1 | ROM select, active low |
| uart_sel_n | input | 1 | UART select, active low |
| snd_sel_n | input | 1 | Sound device select, active low |
| vid_sel_n | input | 1 | Video device select, active low |
| dev_wait_n | input | 1 | Video device wait output, active low |
| rdy_n | output | 1 | CPU ready, low while stalling (registered) |
| ws_count | output | 3 | Generated wait states remaining in this cycle |

## Verification
A wrong class lookup or priority shows up immediately on `ws_count`, one clock after the strobe edge. A wrong count also shows up as a stall that is one or more clocks too long or too short. A handover flag that sets on the wrong cycle, or fails to clear, has a different signature. Either a non-video cycle reacts to `dev_wait_n`, or a video stall ends at the wrong edge relative to the release of the device wait. Both are visible within N+2 clocks of the strobe. A stuck handover flag also corrupts the ready line of the next cycle.

// File: rtl/whg_pkg.sv
package whg_pkg;
  typedef enum logic [1:0] {
    CLS_FREE  = 2'd0,
    CLS_ROM   = 2'd1,
    CLS_SOUND = 2'd2,
    CLS_VIDEO = 2'd3
  } dev_class_e;
endpackage

// File: rtl/whg_class_decode.sv
module whg_class_decode #(
  parameter int WS_W   = 3,
  parameter int SND_WS = 2,
  parameter int ROM_WS = 1,
  parameter int VID_WS = 1,
  parameter int UART_WS = 0
) (
  input  logic            rom_sel_n,
  input  logic            uart_sel_n,
  input  logic            snd_sel_n,
  input  logic            vid_sel_n,
  output whg_pkg::dev_class_e cls,
  output logic [WS_W-1:0] load_val
);
  import whg_pkg::*;

  always_comb begin
    if (!snd_sel_n) begin
      cls      = CLS_SOUND;
      load_val = WS_W'(SND_WS);
    end else if (!vid_sel_n) begin
      cls      = CLS_VIDEO;
      load_val = WS_W'(VID_WS);
    end else if (!rom_sel_n) begin
      cls      = CLS_ROM;
      load_val = WS_W'(ROM_WS);
    end else if (!uart_sel_n) begin
      cls      = CLS_FREE;
      load_val = WS_W'(UART_WS);
    end else begin
      cls      = CLS_FREE;
      load_val = '0;
    end
  end
endmodule

// File: rtl/whg_edge_sampler.sv
module whg_edge_sampler #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/whg_countdown.sv
module whg_countdown #(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [WS_W-1:0] load_val,
  input  logic            load_video,
  input  logic            wait_s_n,
  output logic [WS_W-1:0] cnt_q,
  output logic            rdy_n_q
);
  logic [WS_W-1:0] cnt_d;
  logic            hand_q, hand_d;
  logic            dev_stall;

  always_comb begin
    if (start)              cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;

    dev_stall = hand_d && (cnt_d == '0) && !wait_s_n;

    if (start)       hand_d = load_video;
    else             hand_d = hand_q && !((cnt_d == '0) && wait_s_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      hand_q  <= 1'b0;
      rdy_n_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      hand_q  <= hand_d;
      rdy_n_q <= !((cnt_d != '0) || dev_stall);
    end
  end

  AST_CNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R10

  AST_FIXED_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!start && !hand_q && cnt_q == WS_W'(1)) |=> rdy_n_q); // R8

  AST_HAND_STALL: assert property (@(posedge clk) disable iff (rst)
    (!start && hand_q && cnt_q == '0 && !wait_s_n) |=> !rdy_n_q); // R7

  AST_HAND_END: assert property (@(posedge clk) disable iff (rst)
    (!start && hand_q && cnt_q == '0 && wait_s_n) |=> (rdy_n_q && !hand_q)); // R7
endmodule

// File: rtl/wait_handover_gen.sv
module wait_handover_gen #(
  parameter int WS_W          = 3,
  parameter int SND_WS        = 2,
  parameter int ROM_WS        = 1,
  parameter int VID_WS        = 1,
  parameter int UART_WS       = 0,
  parameter int SAMPLE_STAGES = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cyc_start,
  input  logic            rom_sel_n,
  input  logic            uart_sel_n,
  input  logic            snd_sel_n,
  input  logic            vid_sel_n,
  input  logic            dev_wait_n,
  output logic            rdy_n,
  output logic [WS_W-1:0] ws_count
);
  import whg_pkg::*;

  localparam int MAX_WS = (SND_WS > ROM_WS) ?
                          ((SND_WS > VID_WS) ? SND_WS : VID_WS) :
                          ((ROM_WS > VID_WS) ? ROM_WS : VID_WS);

  dev_class_e      cls;
  logic [WS_W-1:0] load_val;
  logic            wait_s_n;

  whg_class_decode #(
    .WS_W(WS_W), .SND_WS(SND_WS), .ROM_WS(ROM_WS),
    .VID_WS(VID_WS), .UART_WS(UART_WS)
  ) u_decode (
    .rom_sel_n (rom_sel_n),
    .uart_sel_n(uart_sel_n),
    .snd_sel_n (snd_sel_n),
    .vid_sel_n (vid_sel_n),
    .cls       (cls),
    .load_val  (load_val)
  );

  whg_edge_sampler #(.STAGES(SAMPLE_STAGES)) u_sample (
    .clk (clk),
    .rst (rst),
    .din (dev_wait_n),
    .dout(wait_s_n)
  );

  whg_countdown #(.WS_W(WS_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .start     (cyc_start),
    .load_val  (load_val),
    .load_video(cls == CLS_VIDEO),
    .wait_s_n  (wait_s_n),
    .cnt_q     (ws_count),
    .rdy_n_q   (rdy_n)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (rdy_n && ws_count == '0)); // R1

  AST_LOAD_BOUND: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> (ws_count <= WS_W'(MAX_WS))); // R5
endmodule

// File: tb/sim_wait_handover_gen.sv
module sim_wait_handover_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 1'b0;
  logic rom_sel_n = 1'b1, uart_sel_n = 1'b1, snd_sel_n = 1'b1, vid_sel_n = 1'b1;
  logic dev_wait_n = 1'b1;
  logic rdy_n;
  logic [2:0] ws_count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wait_handover_gen u0 (
    .clk(clk), .rst(rst), .cyc_start(cyc_start),
    .rom_sel_n(rom_sel_n), .uart_sel_n(uart_sel_n),
    .snd_sel_n(snd_sel_n), .vid_sel_n(vid_sel_n),
    .dev_wait_n(dev_wait_n), .rdy_n(rdy_n), .ws_count(ws_count)
  );

  // sel bits: [3]=snd [2]=vid [1]=rom [0]=uart, 1 = selected
  function automatic int exp_ws(input logic [3:0] sel);
    if (sel[3]) return 2;
    if (sel[2]) return 1;
    if (sel[1]) return 1;
    return 0;
  endfunction

  function automatic int exp_stall(input logic [3:0] sel, input int n);
    if (!sel[3] && sel[2]) return 1 + n;
    return exp_ws(sel);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // n = clock edges (starting at the strobe edge) with dev_wait_n low
  task automatic run_cycle(input logic [3:0] sel, input int n, input string req);
    int stall = 0;
    int ews = exp_ws(sel);
    @(negedge clk);
    {snd_sel_n, vid_sel_n, rom_sel_n, uart_sel_n} = ~sel;
    cyc_start = 1'b1;
    dev_wait_n = (n > 0) ? 1'b0 : 1'b1;
    for (int e = 0; e < 40; e++) begin
      bit low;
      @(posedge clk);
      #1;
      if (e == 0) check(ws_count == 3'(ews), {req, " ws_count"}, ws_count, ews);
      else if (e < ews) check(ws_count == 3'(ews - e), "R10 decrement", ws_count, ews - e);
      low = !rdy_n;
      if (low) stall++;
      @(negedge clk);
      if (e == 0) begin
        cyc_start = 1'b0;
        {snd_sel_n, vid_sel_n, rom_sel_n, uart_sel_n} = 4'($urandom()); // R9
      end
      if (e == n - 1) dev_wait_n = 1'b1;
      if (!low) break;
    end
    dev_wait_n = 1'b1;
    {snd_sel_n, vid_sel_n, rom_sel_n, uart_sel_n} = 4'hF;
    check(stall == exp_stall(sel, n), {req, " stall"}, stall, exp_stall(sel, n));
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(posedge clk);
    #1;
    check(rdy_n == 1'b1, "R1 rdy_n", rdy_n, 1);
    check(ws_count == 3'd0, "R1 ws_count", ws_count, 0);
    @(negedge clk);
    rst = 1'b0;

    run_cycle(4'b1000, 0, "R2");
    run_cycle(4'b0010, 0, "R3");
    run_cycle(4'b0001, 0, "R4");
    run_cycle(4'b0000, 0, "R4");
    run_cycle(4'b0100, 0, "R6");
    run_cycle(4'b0100, 1, "R7");
    run_cycle(4'b0100, 4, "R7");
    run_cycle(4'b0100, 9, "R7");
    run_cycle(4'b1100, 3, "R5");
    run_cycle(4'b0110, 3, "R5");
    run_cycle(4'b0011, 0, "R5");
    run_cycle(4'b1000, 5, "R8");
    run_cycle(4'b0010, 3, "R8");
    run_cycle(4'b0001, 2, "R8");

    for (int i = 0; i < 40; i++) begin
      logic [3:0] s = 4'($urandom());
      int n = int'($urandom_range(0, 6));
      run_cycle(s, n, "R9");
    end

    // reset in the middle of a stall
    @(negedge clk);
    snd_sel_n = 1'b0; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0; snd_sel_n = 1'b1; rst = 1'b1;
    @(posedge clk);
    #1;
    check(rdy_n == 1'b1 && ws_count == 3'd0, "R1 mid-cycle reset", {29'd0, ws_count}, 0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule